// File: doc/BRIEF.md
# Load-Adaptive PWM Frequency Scheduler

This block turns a digitized error-amplifier feedback code into the switching schedule of a peak-current-mode flyback controller. The one feedback code does four jobs. It selects the switching period: long periods at light load, a fixed nominal period in the middle band, and shortened periods when the load asks for more than nominal power. It sets the peak-current setpoint code sent to the external current comparator. It freezes that setpoint at a floor at light load. It drops whole switching periods when the load is very low, and the skip comparator has hysteresis.

Each period is stretched or shortened by a slow triangular jitter offset. The jitter runs in every region. A gate-enable pulse starts each non-skipped period. The pulse ends at the duty limit, or earlier when the current-limit input is seen after a leading-edge blanking window. All timing advances only on cycles where the clock-enable input is high. Voltages use 5 mV per code LSB, so 1.9 V is code 380, 3.2 V is code 640, and 0.8 V is code 160.

Top module: `pwm_freq_sched`

## Requirements
- R1: While reset is asserted, `gate_o` is 0, `setpt_o` is 0 and `mode_o` is 0.
- R2: For feedback codes 380 to 640 inclusive, the base period is NOM_PER counts (100 in the bench).
- R3: For codes above 640, the base period is NOM_PER − floor((NOM_PER−MIN_PER)·(fb−640)/160). It is held at MIN_PER for codes of 800 and above.
- R4: For codes below 380, the base period is NOM_PER + floor((MAX_PER−NOM_PER)·(380−fb)/80). It is held at MAX_PER for codes of 300 and below.
- R5: For feedback codes of 200 or more, the setpoint is floor(fb/4), capped at code 160.
- R6: For feedback codes below 200, the setpoint is frozen at code 50.
- R7: `setpt_o` never exceeds `ss_code`. It equals min(setpoint of R5/R6, ss_code) one enabled cycle after the inputs.
- R8: Skip mode starts when fb < 80 and ends only when fb ≥ 86. Codes 80 to 85 keep the previous state. A period that starts in skip mode produces no gate pulse.
- R9: Each period is the base period plus a jitter offset. The offset follows a triangle 0, +1 … +J, J−1 … −J, −J+1 … 0, where J = floor(NOM_PER·JIT_PCT/100). The offset moves one count every JIT_STEP periods. The jitter is active in every region. With JIT_STEP = 1, any 4J consecutive periods sum to exactly 4J times the base period.
- R10: With no current-limit trip, the gate stays high for floor(P·DUTY_PCT/100) cycles of a period of P cycles. DUTY_PCT is 80.
- R11: `ilim_trip` is ignored during the first LEB_CYC cycles of a pulse. After that, if it is high at a clock edge, the gate is low from that edge on. A trip in pulse cycle k ≥ LEB_CYC (the rise cycle is 0) therefore gives a pulse k+1 cycles wide.
- R12: While `clk_en` is low, `gate_o`, `setpt_o` and `mode_o` hold their values, whatever the other inputs do.
- R13: `mode_o` encodes 0 = skip, 1 = foldback (fb < 380), 2 = nominal (380 to 640), 3 = boost (fb > 640). Skip takes precedence over the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Advances all timing and registers when high |
| fb_code | input | FB_W | Feedback code, 5 mV per LSB |
| ss_code | input | FB_W | Soft-start ramp code; upper bound on the setpoint |
| ilim_trip | input | 1 | Synchronous current-limit comparator result |
| gate_o | output | 1 | Gate-enable pulse train |
| setpt_o | output | FB_W | Peak-current setpoint code |
| mode_o | output | 2 | Operating region (encoding in R13) |

## Verification
The gate state machine has five states. IDLE (after reset) launches a period on the first enabled cycle. A launch always moves to SKIP or BLANK. BLANK moves to SENSE when the blanking count expires, or to OFF at the duty limit. SENSE moves to OFF on a trip or at the duty limit. OFF and SKIP wait for the period end, which is the next launch.

Two functions meet in the same cycle when the blanking window expires just as the current limit is raised. The bench raises `ilim_trip` in the last blanked cycle and then in the first sensed cycle of a pulse. The first trip must leave the full duty-limited width. The second must give a width of exactly LEB_CYC+1. A second meeting point is a change of skip state that lands on a period launch. The bench sweeps the feedback code across the hysteresis band. It judges by counting gate rises over windows longer than the longest period.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

    typedef enum logic [1:0] {
        MODE_SKIP  = 2'd0,
        MODE_FOLD  = 2'd1,
        MODE_NOM   = 2'd2,
        MODE_BOOST = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLANK,
        ST_SENSE,
        ST_OFF,
        ST_SKIP
    } gate_st_t;

    function automatic int mv2code(input int mv, input int lsb_mv);
        return mv / lsb_mv;
    endfunction

endpackage

// File: rtl/fsched_map.sv
module fsched_map import fsched_pkg::*; #(
    parameter int FB_W    = 10,
    parameter int MV_LSB  = 5,
    parameter int PER_W   = 13,
    parameter int NOM_PER = 1538,
    parameter int MIN_PER = 769,
    parameter int MAX_PER = 3846,
    parameter int IRATIO  = 4
) (
    input  logic [FB_W-1:0]  fb_i,
    output logic [PER_W-1:0] base_per_o,
    output logic [FB_W-1:0]  sp_raw_o,
    output mode_t            region_o
);
    localparam int FOLD_LO  = mv2code(1500, MV_LSB);
    localparam int FOLD_HI  = mv2code(1900, MV_LSB);
    localparam int BOOST_LO = mv2code(3200, MV_LSB);
    localparam int BOOST_HI = mv2code(4000, MV_LSB);
    localparam int FREEZE   = mv2code(1000, MV_LSB);
    localparam int SP_MAX   = mv2code(800, MV_LSB);
    localparam int SP_FRZ   = mv2code(250, MV_LSB);

    int fb;
    int per;
    int sp;

    always_comb begin
        fb = int'(fb_i);
        if (fb >= BOOST_HI) begin
            per = MIN_PER;
        end else if (fb > BOOST_LO) begin
            per = NOM_PER - ((NOM_PER - MIN_PER) * (fb - BOOST_LO)) / (BOOST_HI - BOOST_LO);
        end else if (fb >= FOLD_HI) begin
            per = NOM_PER;
        end else if (fb > FOLD_LO) begin
            per = NOM_PER + ((MAX_PER - NOM_PER) * (FOLD_HI - fb)) / (FOLD_HI - FOLD_LO);
        end else begin
            per = MAX_PER;
        end

        if (fb < FREEZE) begin
            sp = SP_FRZ;
        end else if ((fb / IRATIO) > SP_MAX) begin
            sp = SP_MAX;
        end else begin
            sp = fb / IRATIO;
        end

        if (fb < FOLD_HI) begin
            region_o = MODE_FOLD;
        end else if (fb > BOOST_LO) begin
            region_o = MODE_BOOST;
        end else begin
            region_o = MODE_NOM;
        end

        base_per_o = PER_W'(per);
        sp_raw_o   = FB_W'(sp);
    end

endmodule

// File: rtl/fsched_jitter.sv
module fsched_jitter #(
    parameter int AMP  = 76,
    parameter int STEP = 14,
    parameter int JW   = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    output logic signed [JW-1:0] ofs_o
);
    localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;

    generate
        if (AMP == 0) begin : g_flat
            assign ofs_o = '0;
        end else begin : g_tri
            logic signed [JW-1:0] ofs_q;
            logic [SW-1:0]        div_q;
            logic                 up_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ofs_q <= '0;
                    div_q <= '0;
                    up_q  <= 1'b1;
                end else if (adv_i) begin
                    if (div_q == SW'(STEP - 1)) begin
                        div_q <= '0;
                        if (up_q) begin
                            ofs_q <= ofs_q + JW'(1);
                            if (int'(ofs_q) == AMP - 1) up_q <= 1'b0;
                        end else begin
                            ofs_q <= ofs_q - JW'(1);
                            if (int'(ofs_q) == 1 - AMP) up_q <= 1'b1;
                        end
                    end else begin
                        div_q <= div_q + SW'(1);
                    end
                end
            end

            assign ofs_o = ofs_q;

            // R9
            jit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(ofs_q) <= AMP) && (int'(ofs_q) >= -AMP));

            // R9
            jit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !adv_i |=> $stable(ofs_q));

            // R9
            jit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                adv_i |=> ((int'(ofs_q) - int'($past(ofs_q)) <= 1) &&
                           (int'(ofs_q) - int'($past(ofs_q)) >= -1)));
        end
    endgenerate

endmodule

// File: rtl/fsched_gate.sv
module fsched_gate import fsched_pkg::*; #(
    parameter int PER_W    = 13,
    parameter int JW       = 9,
    parameter int DUTY_PCT = 80,
    parameter int LEB_CYC  = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_i,
    input  logic                 skip_i,
    input  logic [PER_W-1:0]     base_i,
    input  logic signed [JW-1:0] ofs_i,
    input  logic                 ilim_i,
    output logic                 launch_o,
    output logic                 gate_o
);
    localparam int LEB = (LEB_CYC < 1) ? 1 : LEB_CYC;

    gate_st_t         st_q, st_nx;
    logic [PER_W-1:0] pos_q, per_q, lim_q;
    logic [PER_W-1:0] per_nx, lim_nx;
    logic             launch;
    int               per_sum;

    always_comb begin
        per_sum = int'(base_i) + int'(ofs_i);
        per_nx  = PER_W'(per_sum);
        lim_nx  = PER_W'((per_sum * DUTY_PCT) / 100);
    end

    always_comb begin
        launch = ce_i && ((st_q == ST_IDLE) || (pos_q == per_q - PER_W'(1)));
        st_nx  = st_q;
        if (launch) begin
            st_nx = skip_i ? ST_SKIP : ST_BLANK;
        end else begin
            unique case (st_q)
                ST_BLANK: begin
                    if (pos_q == lim_q - PER_W'(1))      st_nx = ST_OFF;
                    else if (pos_q == PER_W'(LEB - 1))   st_nx = ST_SENSE;
                end
                ST_SENSE: begin
                    if (ilim_i || (pos_q == lim_q - PER_W'(1))) st_nx = ST_OFF;
                end
                ST_IDLE, ST_OFF, ST_SKIP: st_nx = st_q;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (ce_i) begin
            st_q <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            per_q <= '0;
            lim_q <= '0;
        end else if (ce_i) begin
            if (launch) begin
                pos_q <= '0;
                per_q <= per_nx;
                lim_q <= lim_nx;
            end else begin
                pos_q <= pos_q + PER_W'(1);
            end
        end
    end

    always_comb begin
        gate_o   = (st_q == ST_BLANK) || (st_q == ST_SENSE);
        launch_o = launch;
    end

    // R10
    duty_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (pos_q < lim_q));

    // R11
    ilim_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && (st_q == ST_SENSE) && ilim_i && !launch) |=> !gate_o);

    // R11
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_o)) |-> (pos_q == '0));

endmodule

// File: rtl/pwm_freq_sched.sv
module pwm_freq_sched import fsched_pkg::*; #(
    parameter int FB_W     = 10,
    parameter int MV_LSB   = 5,
    parameter int NOM_PER  = 1538,
    parameter int MIN_PER  = 769,
    parameter int MAX_PER  = 3846,
    parameter int JIT_PCT  = 5,
    parameter int JIT_STEP = 14,
    parameter int DUTY_PCT = 80,
    parameter int LEB_CYC  = 30,
    parameter int IRATIO   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic [FB_W-1:0] fb_code,
    input  logic [FB_W-1:0] ss_code,
    input  logic            ilim_trip,
    output logic            gate_o,
    output logic [FB_W-1:0] setpt_o,
    output logic [1:0]      mode_o
);
    localparam int JIT_AMP  = (NOM_PER * JIT_PCT) / 100;
    localparam int PER_W    = $clog2(MAX_PER + JIT_AMP + 1) + 1;
    localparam int JW       = $clog2(JIT_AMP + 1) + 2;
    localparam int SKIP_ON  = mv2code(400, MV_LSB);
    localparam int SKIP_OFF = mv2code(430, MV_LSB);
    localparam int FREEZE   = mv2code(1000, MV_LSB);
    localparam int SP_FRZ   = mv2code(250, MV_LSB);
    localparam int SP_MAX   = mv2code(800, MV_LSB);

    logic [PER_W-1:0]     base_per;
    logic [FB_W-1:0]      sp_raw;
    mode_t                region;
    logic signed [JW-1:0] jit_ofs;
    logic                 launch;
    logic                 skip_q, skip_nx;
    mode_t                mode_q;
    logic [FB_W-1:0]      sp_q;

    fsched_map #(
        .FB_W(FB_W), .MV_LSB(MV_LSB), .PER_W(PER_W), .NOM_PER(NOM_PER),
        .MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .IRATIO(IRATIO)
    ) u_map (
        .fb_i(fb_code), .base_per_o(base_per), .sp_raw_o(sp_raw), .region_o(region)
    );

    fsched_jitter #(.AMP(JIT_AMP), .STEP(JIT_STEP), .JW(JW)) u_jit (
        .clk(clk), .rst_n(rst_n), .adv_i(launch), .ofs_o(jit_ofs)
    );

    fsched_gate #(.PER_W(PER_W), .JW(JW), .DUTY_PCT(DUTY_PCT), .LEB_CYC(LEB_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .ce_i(clk_en), .skip_i(skip_q), .base_i(base_per),
        .ofs_i(jit_ofs), .ilim_i(ilim_trip), .launch_o(launch), .gate_o(gate_o)
    );

    always_comb begin
        if (int'(fb_code) < SKIP_ON)        skip_nx = 1'b1;
        else if (int'(fb_code) >= SKIP_OFF) skip_nx = 1'b0;
        else                                skip_nx = skip_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
            mode_q <= MODE_SKIP;
            sp_q   <= '0;
        end else if (clk_en) begin
            skip_q <= skip_nx;
            mode_q <= skip_nx ? MODE_SKIP : region;
            sp_q   <= (sp_raw < ss_code) ? sp_raw : ss_code;
        end
    end

    always_comb begin
        setpt_o = sp_q;
        mode_o  = mode_q;
    end

    // R8
    skip_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> ($past(skip_q) == 1'b0));

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(gate_o) && $stable(setpt_o) && $stable(mode_o)));

    // R5
    sp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(setpt_o) <= SP_MAX);

    // R6
    sp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && (int'(fb_code) < FREEZE) && (int'(ss_code) >= SP_FRZ))
            |=> (int'(setpt_o) == SP_FRZ));

    // R7
    sp_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (setpt_o <= $past(ss_code)));

endmodule

// File: tb/pwm_freq_sched_bench.sv
module pwm_freq_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NOM = 100;
    localparam int MINP = 50;
    localparam int MAXP = 250;
    localparam int J = 5;
    localparam int LEB = 4;
    localparam int WD_CYC = 190000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clk_en;
    logic [9:0] fb;
    logic [9:0] ss;
    logic       ilim;
    logic       gate_o;
    logic [9:0] setpt_o;
    logic [1:0] mode_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_freq_sched #(
        .FB_W(10), .MV_LSB(5), .NOM_PER(NOM), .MIN_PER(MINP), .MAX_PER(MAXP),
        .JIT_PCT(5), .JIT_STEP(1), .DUTY_PCT(80), .LEB_CYC(LEB), .IRATIO(4)
    ) u_pwm_freq_sched (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .fb_code(fb), .ss_code(ss),
        .ilim_trip(ilim), .gate_o(gate_o), .setpt_o(setpt_o), .mode_o(mode_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int f);
        if (f >= 800) return MINP;
        if (f > 640)  return NOM - ((NOM - MINP) * (f - 640)) / 160;
        if (f >= 380) return NOM;
        if (f > 300)  return NOM + ((MAXP - NOM) * (380 - f)) / 80;
        return MAXP;
    endfunction

    function automatic int exp_sp(input int f, input int s);
        int v;
        if (f < 200) v = 50;
        else if (f / 4 > 160) v = 160;
        else v = f / 4;
        return (v < s) ? v : s;
    endfunction

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic last;
        last = gate_o;
        forever begin
            @(negedge clk);
            if (gate_o && !last) break;
            last = gate_o;
        end
    endtask

    task automatic count_rises(input int cyc, output int r);
        logic last;
        last = gate_o;
        r = 0;
        repeat (cyc) begin
            @(negedge clk);
            if (gate_o && !last) r++;
            last = gate_o;
        end
    endtask

    task automatic measure_ilim(input int k, output int w, output int p);
        logic last;
        bit   inp;
        int   pos;
        wait_rise();
        pos = 0; w = 1; p = 1; inp = 1; last = 1'b1;
        if (k == 0) ilim = 1'b1;
        forever begin
            @(negedge clk);
            ilim = 1'b0;
            if (gate_o && !last) break;
            pos++; p++;
            if (inp && gate_o) w++; else inp = 0;
            if (pos == k) ilim = 1'b1;
            last = gate_o;
        end
    endtask

    // R2 R3 R4 R9: 4J consecutive periods, sum and jitter extremes
    task automatic check_period(input int fbv, input string req);
        int base, tot, mn, mx, len, n;
        logic last;
        base = exp_period(fbv);
        fb = 10'(fbv);
        repeat (2) wait_rise();
        tot = 0; mn = 1 << 30; mx = 0; len = 0; n = 0; last = 1'b1;
        while (n < 4 * J) begin
            @(negedge clk);
            len++;
            if (gate_o && !last) begin
                tot += len;
                if (len < mn) mn = len;
                if (len > mx) mx = len;
                len = 0;
                n++;
            end
            last = gate_o;
        end
        chk(tot == 4 * J * base, req, tot, 4 * J * base);
        chk(mx == base + J, "R9 max", mx, base + J);
        chk(mn == base - J, "R9 min", mn, base - J);
    endtask

    task automatic t_reset();
        chk(gate_o == 1'b0, "R1 gate", int'(gate_o), 0);
        chk(setpt_o == 10'd0, "R1 setpt", int'(setpt_o), 0);
        chk(mode_o == 2'd0, "R1 mode", int'(mode_o), 0);
    endtask

    task automatic t_nominal();
        check_period(380, "R2");
        check_period(500, "R2");
        check_period(640, "R2");
    endtask

    task automatic t_boost();
        check_period(680, "R3");
        check_period(720, "R3");
        check_period(800, "R3");
        check_period(900, "R3");
    endtask

    task automatic t_fold();
        check_period(340, "R4");
        check_period(301, "R4");
        check_period(300, "R4");
        check_period(200, "R4");
    endtask

    task automatic t_setpoint();
        int vals[8] = '{500, 600, 640, 644, 700, 210, 200, 199};
        ss = 10'd1023;
        foreach (vals[i]) begin
            fb = 10'(vals[i]);
            settle();
            chk(int'(setpt_o) == exp_sp(vals[i], 1023), vals[i] < 200 ? "R6" : "R5",
                int'(setpt_o), exp_sp(vals[i], 1023));
        end
        fb = 10'd100;
        settle();
        chk(int'(setpt_o) == 50, "R6 deep", int'(setpt_o), 50);
    endtask

    task automatic t_softstart();
        ss = 10'd100; fb = 10'd600;
        settle();
        chk(int'(setpt_o) == 100, "R7 cap", int'(setpt_o), 100);
        ss = 10'd30; fb = 10'd100;
        settle();
        chk(int'(setpt_o) == 30, "R7 freeze cap", int'(setpt_o), 30);
        ss = 10'd1023;
        settle();
        chk(int'(setpt_o) == 50, "R7 release", int'(setpt_o), 50);
    endtask

    task automatic t_mode();
        fb = 10'd300; settle();
        chk(mode_o == 2'd1, "R13 fold", int'(mode_o), 1);
        fb = 10'd500; settle();
        chk(mode_o == 2'd2, "R13 nominal", int'(mode_o), 2);
        fb = 10'd641; settle();
        chk(mode_o == 2'd3, "R13 boost", int'(mode_o), 3);
        fb = 10'd60; settle();
        chk(mode_o == 2'd0, "R13 skip", int'(mode_o), 0);
    endtask

    task automatic t_skip();
        int r;
        fb = 10'd90; settle();
        chk(mode_o == 2'd1, "R8 above", int'(mode_o), 1);
        fb = 10'd82; settle();
        chk(mode_o == 2'd1, "R8 band from run", int'(mode_o), 1);
        fb = 10'd79; settle();
        chk(mode_o == 2'd0, "R8 enter", int'(mode_o), 0);
        repeat (300) @(negedge clk);
        count_rises(600, r);
        chk(r == 0, "R8 no pulses", r, 0);
        fb = 10'd84; settle();
        chk(mode_o == 2'd0, "R8 band from skip", int'(mode_o), 0);
        count_rises(600, r);
        chk(r == 0, "R8 band no pulses", r, 0);
        fb = 10'd86; settle();
        chk(mode_o == 2'd1, "R8 exit", int'(mode_o), 1);
        count_rises(600, r);
        chk(r >= 2, "R8 pulses resume", r, 2);
    endtask

    task automatic t_duty();
        int w, p;
        fb = 10'd500; repeat (2) wait_rise();
        measure_ilim(-1, w, p);
        chk(w == (p * 80) / 100, "R10 nominal", w, (p * 80) / 100);
        fb = 10'd800; repeat (2) wait_rise();
        measure_ilim(-1, w, p);
        chk(w == (p * 80) / 100, "R10 boost", w, (p * 80) / 100);
        fb = 10'd250; repeat (2) wait_rise();
        measure_ilim(-1, w, p);
        chk(w == (p * 80) / 100, "R10 fold", w, (p * 80) / 100);
    endtask

    task automatic t_ilim();
        int w, p;
        fb = 10'd500; repeat (2) wait_rise();
        measure_ilim(20, w, p);
        chk(w == 21, "R11 mid trip", w, 21);
        measure_ilim(LEB, w, p);
        chk(w == LEB + 1, "R11 first sensed", w, LEB + 1);
        measure_ilim(LEB - 1, w, p);
        chk(w == (p * 80) / 100, "R11 last blanked", w, (p * 80) / 100);
        measure_ilim(1, w, p);
        chk(w == (p * 80) / 100, "R11 early blanked", w, (p * 80) / 100);
    endtask

    task automatic t_clken();
        int bad, r;
        logic [9:0] sp0;
        logic [1:0] md0;
        fb = 10'd500; repeat (2) wait_rise();
        repeat (3) @(negedge clk);
        sp0 = setpt_o; md0 = mode_o;
        clk_en = 1'b0;
        fb = 10'd900; ss = 10'd10; ilim = 1'b1;
        bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (gate_o !== 1'b1 || setpt_o !== sp0 || mode_o !== md0) bad++;
        end
        chk(bad == 0, "R12 stall", bad, 0);
        ilim = 1'b0; fb = 10'd500; ss = 10'd1023;
        clk_en = 1'b1;
        count_rises(300, r);
        chk(r >= 2, "R12 resume", r, 2);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYC);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_en = 1'b1; fb = 10'd500; ss = 10'd1023; ilim = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nominal();
        t_boost();
        t_fold();
        t_setpoint();
        t_softstart();
        t_mode();
        t_skip();
        t_duty();
        t_ilim();
        t_clken();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule